// File: doc/BRIEF.md
# Latched Alarm Status Register Bank

This block gathers the sticky status bits of a telecom framer receiver into registers that a host can read. It watches live timer, signaling and alarm inputs that other logic drives. It turns their rising edges into latched bits that stay set until the host acknowledges them. Two kinds of latch are kept.

Event latches cover the signaling-change flag and four timer flags. They catch a zero-to-one change once per basic frame, or once per multiframe for the alignment timer. Any read of the event register, or of the interrupt status register that mirrors it, clears them. Alarm latches cover remote alarm, AIS, loss of signal and frame alignment. They catch a rising edge of the live alarm. A read clears one only if its live alarm has already gone away.

Two host-writable enable masks select which latched bits drive the interrupt line.

Top module: `alarm_latch_bank`

## Requirements
- R1: On a cycle with `frame_pulse` high, a live timer input that is 1 sets its event latch if it was 0 at the previous frame pulse. The bits are onesec = bit0, 100 ms = bit1 and 10 ms = bit2 of the event register (address 0). Nothing is captured on cycles without `frame_pulse`.
- R2: The alignment-timer latch (event bit3) is sampled only on cycles with `mframe_pulse` high. It sets when `calign_st` is 1 there and was 0 at the previous multiframe pulse. Frame pulses alone never set it.
- R3: Event bit4 sets on a frame pulse when `sig_abcd` differs from the word seen at the previous frame pulse. The first frame pulse after reset only stores the word and sets nothing.
- R4: A read of address 0 or address 2 returns the event latches in bits 4:0 as they stood before the read. The event latches read as 0 from the next cycle on.
- R5: If a latch sets in the same cycle as a clearing read, the latch holds 1 afterwards.
- R6: Each alarm latch in the alarm register (address 1) sets when its live input goes from 0 to 1 between consecutive clocks. The bits are bfa = bit0, los = bit1, ais = bit2 and rai = bit3.
- R7: A read of address 1 clears an alarm latch only if its live input is 0 in that cycle. A latch whose live input is 1 stays set.
- R8: Bits 7:5 of addresses 0 and 2, bits 7:4 of addresses 1 and 4, and every bit of addresses 5 to 7 read as 0.
- R9: `irq` is high exactly when some event latch is set with its bit set in the event mask (address 3, bits 4:0), or some alarm latch is set with its bit set in the alarm mask (address 4, bits 3:0). Writes go to these masks, and a 1 enables a bit. Both masks read back.
- R10: After reset all latches and both masks are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Basic frame qualifier |
| mframe_pulse | input | 1 | Multiframe / 2 ms qualifier |
| sig_abcd | input | SIG_BITS | Received signaling bits |
| onesec_st | input | 1 | Live one-second timer status |
| t100_st | input | 1 | Live 100 ms timer status |
| t10_st | input | 1 | Live 10 ms timer status |
| calign_st | input | 1 | Live multiframe alignment timer status |
| bfa_st | input | 1 | Live basic frame alignment status |
| los_st | input | 1 | Live loss of signal status |
| ais_st | input | 1 | Live AIS status |
| rai_st | input | 1 | Live remote alarm status |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach involve an alarm register read while the live alarm is still high. Harder still is a read that lands in the same cycle as a fresh edge, either on a frame or multiframe qualifier or on an alarm input. Directed sequences hold an alarm high across repeated reads and then drop it. They also place a timer rise and a clearing read in one cycle. A long seeded random run then toggles the live inputs slowly and reads often, so that these coincidences recur across every register. It compares every read and the interrupt line against a bench model.

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank #(
  parameter int SIG_BITS = 8,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_pulse,
  input  logic                mframe_pulse,
  input  logic [SIG_BITS-1:0] sig_abcd,
  input  logic                onesec_st,
  input  logic                t100_st,
  input  logic                t10_st,
  input  logic                calign_st,
  input  logic                bfa_st,
  input  logic                los_st,
  input  logic                ais_st,
  input  logic                rai_st,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq
);
  localparam int EV_N = 5;
  localparam int PL_N = 4;
  localparam logic [AW-1:0] A_EV = AW'(0);
  localparam logic [AW-1:0] A_PL = AW'(1);
  localparam logic [AW-1:0] A_IS = AW'(2);
  localparam logic [AW-1:0] A_EM = AW'(3);
  localparam logic [AW-1:0] A_PM = AW'(4);

  logic [3:0]          tm_live, tm_prev, tm_set;
  logic [SIG_BITS-1:0] sig_prev;
  logic                sig_primed, sig_set;
  logic [EV_N-1:0]     ev_set, ev_q, em_q;
  logic [PL_N-1:0]     pl_live, pl_prev, pl_set, pl_clr, pl_q, pm_q;
  logic                rd, rd_ev, rd_pl, wr;

  assign tm_live = {calign_st, t10_st, t100_st, onesec_st};
  assign pl_live = {rai_st, ais_st, los_st, bfa_st};

  assign tm_set[2:0] = {3{frame_pulse}} & tm_live[2:0] & ~tm_prev[2:0];
  assign tm_set[3]   = mframe_pulse & tm_live[3] & ~tm_prev[3];
  assign sig_set     = frame_pulse & sig_primed & (sig_abcd != sig_prev);
  assign ev_set      = {sig_set, tm_set};
  assign pl_set      = pl_live & ~pl_prev;

  assign rd     = bus_sel & ~bus_wr;
  assign wr     = bus_sel & bus_wr;
  assign rd_ev  = rd & ((bus_addr == A_EV) | (bus_addr == A_IS));
  assign rd_pl  = rd & (bus_addr == A_PL);
  assign pl_clr = {PL_N{rd_pl}} & ~pl_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm_prev    <= '0;
      sig_prev   <= '0;
      sig_primed <= 1'b0;
    end else begin
      if (frame_pulse) begin
        tm_prev[2:0] <= tm_live[2:0];
        sig_prev     <= sig_abcd;
        sig_primed   <= 1'b1;
      end
      if (mframe_pulse) tm_prev[3] <= tm_live[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q    <= '0;
      pl_q    <= '0;
      pl_prev <= '0;
    end else begin
      ev_q    <= (ev_q & ~{EV_N{rd_ev}}) | ev_set;
      pl_q    <= (pl_q & ~pl_clr) | pl_set;
      pl_prev <= pl_live;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      em_q <= '0;
      pm_q <= '0;
    end else if (wr) begin
      if (bus_addr == A_EM) em_q <= bus_wdata[EV_N-1:0];
      if (bus_addr == A_PM) pm_q <= bus_wdata[PL_N-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_EV, A_IS: bus_rdata = {{(DW-EV_N){1'b0}}, ev_q};
      A_PL:       bus_rdata = {{(DW-PL_N){1'b0}}, pl_q};
      A_EM:       bus_rdata = {{(DW-EV_N){1'b0}}, em_q};
      A_PM:       bus_rdata = {{(DW-PL_N){1'b0}}, pm_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = (|(ev_q & em_q)) | (|(pl_q & pm_q));
endmodule

// File: rtl/alarm_latch_bank_chk.sv
module alarm_latch_bank_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_pulse,
  input logic          mframe_pulse,
  input logic          t10_st,
  input logic [3:0]    tm_prev,
  input logic [4:0]    ev_set,
  input logic [4:0]    ev_q,
  input logic [3:0]    pl_live,
  input logic [3:0]    pl_q,
  input logic          rd_ev,
  input logic          rd_pl,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata
);
  assert_t10_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && t10_st && !tm_prev[2]) |=> ev_q[2]);

  assert_mframe_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mframe_pulse |=> (tm_prev[3] == $past(tm_prev[3])));

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> ((ev_q & ~$past(ev_set)) == 5'd0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((ev_q & $past(ev_set)) == $past(ev_set)));

  assert_alarm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pl |=> ((pl_q & $past(pl_live & pl_q)) == $past(pl_live & pl_q)));

  assert_alarm_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pl |=> ((pl_q & ~$past(pl_live)) == 4'd0));

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(1)) |-> (bus_rdata[DW-1:4] == '0));
endmodule

bind alarm_latch_bank alarm_latch_bank_chk #(.DW(DW), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .mframe_pulse(mframe_pulse),
  .t10_st(t10_st), .tm_prev(tm_prev), .ev_set(ev_set), .ev_q(ev_q),
  .pl_live(pl_live), .pl_q(pl_q), .rd_ev(rd_ev), .rd_pl(rd_pl),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/alarm_latch_bank_test.sv
`timescale 1ns/1ps
module alarm_latch_bank_test;
  logic clk = 0, rst_n = 0;
  logic fp = 0, mfp = 0;
  logic [7:0] sig = 0;
  logic onesec = 0, t100 = 0, t10 = 0, calign = 0;
  logic bfa = 0, los = 0, ais = 0, rai = 0;
  logic sel = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit finished = 0;

  logic [3:0] m_tprev = 0, m_pprev = 0, m_pl = 0, m_pm = 0;
  logic [7:0] m_sprev = 0;
  logic m_primed = 0;
  logic [4:0] m_ev = 0, m_em = 0;

  always #4 clk = ~clk;

  alarm_latch_bank uut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(fp), .mframe_pulse(mfp), .sig_abcd(sig),
    .onesec_st(onesec), .t100_st(t100), .t10_st(t10), .calign_st(calign),
    .bfa_st(bfa), .los_st(los), .ais_st(ais), .rai_st(rai),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq(irq)
  );

  function automatic logic [7:0] exp_rdata(input logic [2:0] a);
    case (a)
      3'd0, 3'd2: return {3'b0, m_ev};
      3'd1:       return {4'b0, m_pl};
      3'd3:       return {3'b0, m_em};
      3'd4:       return {4'b0, m_pm};
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m_ev & m_em)) | (|(m_pl & m_pm));
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    logic [3:0] tl, pl, pls;
    logic [4:0] evs;
    #1;
    if (sel && !wr) check(rdata == exp_rdata(addr), tag, rdata, exp_rdata(addr));
    tl = {calign, t10, t100, onesec};
    pl = {rai, ais, los, bfa};
    evs[2:0] = fp ? (tl[2:0] & ~m_tprev[2:0]) : 3'b0;
    evs[3] = mfp & tl[3] & ~m_tprev[3];
    evs[4] = fp & m_primed & (sig != m_sprev);
    m_ev = ((sel && !wr && (addr == 0 || addr == 2)) ? 5'b0 : m_ev) | evs;
    pls = pl & ~m_pprev;
    m_pl = ((sel && !wr && addr == 1) ? (m_pl & pl) : m_pl) | pls;
    m_pprev = pl;
    if (fp) begin m_tprev[2:0] = tl[2:0]; m_sprev = sig; m_primed = 1; end
    if (mfp) m_tprev[3] = tl[3];
    if (sel && wr && addr == 3) m_em = wdata[4:0];
    if (sel && wr && addr == 4) m_pm = wdata[3:0];
    @(posedge clk);
    #1;
    check(irq == exp_irq(), "R9 irq", {7'b0, irq}, {7'b0, exp_irq()});
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    sel = 1; wr = 0; addr = a; tick(tag); sel = 0;
  endtask

  task automatic wrr(input logic [2:0] a, input logic [7:0] d);
    sel = 1; wr = 1; addr = a; wdata = d; tick("R9 write"); sel = 0; wr = 0;
  endtask

  task automatic frame(input string tag);
    fp = 1; tick(tag); fp = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(irq == 1'b0, "R10 irq after reset", {7'b0, irq}, 8'h00);
    @(negedge clk);
    for (int a = 0; a < 5; a++) rd(3'(a), "R10 reset read");

    sig = 8'h5A; frame("R3 prime"); rd(0, "R3 first frame no set");
    sig = 8'h5B; frame("R3"); rd(0, "R3 change sets bit4");

    wrr(3, 8'hFF); wrr(4, 8'hFF);
    rd(3, "R9 mask readback"); rd(4, "R9 mask readback");

    t10 = 1; tick("R1"); rd(0, "R1 no frame no set");
    frame("R1"); rd(0, "R1 set on frame"); rd(2, "R4 cleared after read");

    calign = 1; frame("R2"); frame("R2"); rd(0, "R2 frame alone no set");
    mfp = 1; tick("R2"); mfp = 0; rd(2, "R2 set on mframe");

    t100 = 1; fp = 1; sel = 1; wr = 0; addr = 0; tick("R5 read with set");
    fp = 0; sel = 0; rd(0, "R5 set survives clear");

    los = 1; tick("R6"); rd(1, "R6 los set"); rd(1, "R7 held while live");
    los = 0; tick("R7"); rd(1, "R7 still set before read"); rd(1, "R7 cleared");
    rai = 1; ais = 1; tick("R6"); rai = 0; rd(1, "R7 mixed"); rd(1, "R7 mixed after");

    rd(7, "R8 unmapped"); rd(5, "R8 unmapped");
    wrr(3, 8'h00); wrr(4, 8'h00); tick("R9 masked");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 6000; i++) begin
      string tag;
      fp = ($urandom_range(3) == 0);
      mfp = fp && ($urandom_range(3) == 0);
      if ($urandom_range(7) == 0) sig = sig ^ (8'h1 << $urandom_range(7));
      if ($urandom_range(7) == 0) onesec = ~onesec;
      if ($urandom_range(7) == 0) t100 = ~t100;
      if ($urandom_range(7) == 0) t10 = ~t10;
      if ($urandom_range(7) == 0) calign = ~calign;
      if ($urandom_range(9) == 0) bfa = ~bfa;
      if ($urandom_range(9) == 0) los = ~los;
      if ($urandom_range(9) == 0) ais = ~ais;
      if ($urandom_range(9) == 0) rai = ~rai;
      sel = ($urandom_range(2) == 0);
      wr = sel && ($urandom_range(7) == 0);
      addr = 3'($urandom_range(7));
      wdata = 8'($urandom);
      case (addr)
        3'd0, 3'd2: tag = "R4 random";
        3'd1:       tag = "R7 random";
        3'd3, 3'd4: tag = "R9 random";
        default:    tag = "R8 random";
      endcase
      tick(tag);
    end
    sel = 0; wr = 0; fp = 0; mfp = 0;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule